// File: doc/BRIEF.md
# Write Cycle Qualifier with Glitch Filter

This block sits between the asynchronous control pins of a memory bus and the command logic behind them. It samples the active-low chip enable, write enable and output enable lines on a fast internal clock, passes each through a two-flop synchroniser and then a pulse-width filter, and only then decides whether a genuine write is in progress. When the qualified write enable returns high at the end of a valid cycle, the block issues a one-clock write strobe carrying the address and data captured during that cycle.

Two inhibit conditions gate the strobe. A supply-below-lockout input, driven from an external comparator, blocks all writes and holds a read-mode request toward the command logic. A power-up guard rejects any write cycle that was already under way when reset was released, and the read-mode request is also held through reset and a short settling window afterwards.

The outgoing write interface is a valid-only stream: `wr_valid` is high for exactly one clock per accepted write, and there is no ready input, so the consumer must take every strobe in the cycle it appears. Bus pins must be held steady for the pulse-width threshold before they count.

Top module: `write_qualifier`

## Requirements
- R1: A write is accepted when the filtered chip enable and write enable are low and filtered output enable is high; on the filtered rise of write enable the block raises `wr_valid` with `wr_addr`/`wr_data` equal to the bus values held during that cycle.
- R2: While output enable is low or chip enable is high, no write strobe is produced.
- R3: A low pulse on any control line lasting fewer than `MIN_LOW` clock samples is ignored: a short write or chip enable pulse starts no write, and a short output enable pulse does not cancel a write in progress.
- R4: While `supply_low` is high, no write strobe is produced and `read_mode_req` is high.
- R5: After `supply_low` returns low, a fresh write cycle is accepted, but a write cycle that overlapped the lockout is rejected when it ends.
- R6: `wr_valid` never stays high for two consecutive clocks; one write cycle gives one strobe.
- R7: `read_mode_req` is high during reset and for a settling window after it (cleared within 20 clocks of reset release), and a write cycle already active when reset is released is not accepted.
- R8: A cycle ended by chip enable rising before write enable produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| supply_low | input | 1 | High while supply is below the lockout level |
| bus_addr | input | ADDR_W | Address pins |
| bus_data | input | DATA_W | Data pins |
| wr_valid | output | 1 | One-clock write strobe |
| wr_addr | output | ADDR_W | Address of the accepted write |
| wr_data | output | DATA_W | Data of the accepted write |
| read_mode_req | output | 1 | Forces downstream command logic to read mode |

## Verification
The bench drives pulses just under the filter threshold on write and output enable; a design that counted edges instead of held samples would either start a write from noise or abort a valid one. It holds a write open across a supply dip and across reset release, where a design that only looked at the current inhibit level would accept the trailing edge of a poisoned cycle. It also ends a cycle with chip enable first, which a design keyed on any deassertion would wrongly strobe, and sends back-to-back writes to catch a stale or repeated address capture.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int N_LINES = 3;
  localparam int L_CE = 0;
  localparam int L_WE = 1;
  localparam int L_OE = 2;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= {W{RST_VAL}};
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/wq_filter.sv
module wq_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic active
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

  logic [CW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            held <= '0;
    else if (line_n)       held <= '0;
    else if (held != LIMIT) held <= held + 1'b1;
  end

  assign active = (held == LIMIT);
endmodule

// File: rtl/wq_core.sv
module wq_core #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int MIN_LOW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [wq_pkg::N_LINES-1:0]  act,
  input  logic                        lock,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_data,
  output logic                        wr_valid,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [DATA_W-1:0]           wr_data,
  output logic                        read_mode_req
);
  import wq_pkg::*;

  localparam int SETTLE = MIN_LOW + SYNC_DEPTH + 2;
  localparam int PW = $clog2(SETTLE + 1);
  localparam logic [PW-1:0] SETTLE_V = PW'(SETTLE);

  logic [PW-1:0] settle_cnt;
  logic settled, armed, armed_q, poisoned, strobe;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  assign settled = (settle_cnt == SETTLE_V);
  assign armed   = act[L_CE] & act[L_WE] & ~act[L_OE];
  assign strobe  = armed_q & ~act[L_WE] & ~poisoned & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt    <= '0;
      armed_q       <= 1'b0;
      poisoned      <= 1'b1;
      read_mode_req <= 1'b1;
      wr_valid      <= 1'b0;
      cap_addr      <= '0;
      cap_data      <= '0;
      wr_addr       <= '0;
      wr_data       <= '0;
    end else begin
      if (!settled) settle_cnt <= settle_cnt + 1'b1;
      armed_q       <= armed;
      read_mode_req <= lock | ~settled;
      if (lock || !settled)        poisoned <= 1'b1;
      else if (!armed && !armed_q) poisoned <= 1'b0;
      if (armed) begin
        cap_addr <= bus_addr;
        cap_data <= bus_data;
      end
      wr_valid <= strobe;
      if (strobe) begin
        wr_addr <= cap_addr;
        wr_data <= cap_data;
      end
    end
  end
endmodule

// File: rtl/write_qualifier.sv
module write_qualifier #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int MIN_LOW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              supply_low,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              read_mode_req
);
  import wq_pkg::*;

  logic [N_LINES-1:0] pins_n, synced_n, act;
  logic lock;

  assign pins_n[L_CE] = ce_n;
  assign pins_n[L_WE] = we_n;
  assign pins_n[L_OE] = oe_n;

  wq_sync #(.W(N_LINES), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(pins_n), .q(synced_n)
  );

  wq_sync #(.W(1), .DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_sup (
    .clk(clk), .rst_n(rst_n), .d(supply_low), .q(lock)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    wq_filter #(.MIN_LOW(MIN_LOW)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_n(synced_n[g]), .active(act[g])
    );
  end

  wq_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW(MIN_LOW)) u_core (
    .clk(clk), .rst_n(rst_n), .act(act), .lock(lock),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .read_mode_req(read_mode_req)
  );
endmodule

// File: rtl/wq_checker.sv
module wq_checker #(
  parameter int MIN_LOW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic supply_low,
  input logic wr_valid,
  input logic read_mode_req
);
  localparam int QUIET = MIN_LOW + 6;
  int unsigned blocked_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                blocked_run <= 0;
    else if (!oe_n || ce_n) begin
      if (blocked_run < QUIET) blocked_run <= blocked_run + 1;
    end else                   blocked_run <= 0;
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_lock_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_low, 3) |-> !wr_valid);

  p_lock_read_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_low, 3) |-> read_mode_req);

  p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_run >= QUIET) |-> !wr_valid);
endmodule

bind write_qualifier wq_checker #(.MIN_LOW(MIN_LOW)) u_wq_checker (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .supply_low(supply_low), .wr_valid(wr_valid), .read_mode_req(read_mode_req)
);

// File: tb/write_qualifier_test.sv
module write_qualifier_test;
  localparam int PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int ML = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic wr_valid, read_mode_req;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0, fails = 0, seen = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  always #(PERIOD/2) clk = ~clk;

  write_qualifier #(.ADDR_W(AW), .DATA_W(DW), .MIN_LOW(ML)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .supply_low(supply_low), .bus_addr(bus_addr), .bus_data(bus_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .read_mode_req(read_mode_req)
  );

  always @(negedge clk) if (rst_n && wr_valid) begin
    seen++;
    last_addr = wr_addr;
    last_data = wr_data;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(25); seen = 0;
  endtask

  task automatic full_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int low);
    bus_addr = a; bus_data = d; idle(2);
    ce_n = 1'b0; idle(2);
    we_n = 1'b0; idle(low);
    we_n = 1'b1; idle(3);
    ce_n = 1'b1; idle(10);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(3);
    chk(read_mode_req == 1'b1, "R7 read mode in reset", read_mode_req, 1);
    chk(wr_valid == 1'b0, "R7 no strobe in reset", wr_valid, 0);
    rst_n = 1'b1; idle(20);
    chk(read_mode_req == 1'b0, "R7 read mode released", read_mode_req, 0);
    seen = 0;
  endtask

  task automatic t_basic();
    seen = 0; full_write(20'h1A2B3, 16'hBEEF, 10);
    chk(seen == 1, "R1 one strobe", seen, 1);
    chk(last_addr == 20'h1A2B3, "R1 address", last_addr, 20'h1A2B3);
    chk(last_data == 16'hBEEF, "R1 data", last_data, 16'hBEEF);
  endtask

  task automatic t_oe_low();
    seen = 0; oe_n = 1'b0; idle(2);
    full_write(20'h00011, 16'h1111, 10);
    oe_n = 1'b1; idle(5);
    chk(seen == 0, "R2 OE low inhibits", seen, 0);
  endtask

  task automatic t_ce_high();
    seen = 0; bus_addr = 20'h00022;
    we_n = 1'b0; idle(10); we_n = 1'b1; idle(10);
    chk(seen == 0, "R2 CE high inhibits", seen, 0);
  endtask

  task automatic t_we_glitch();
    seen = 0; full_write(20'h00033, 16'h3333, 2);
    chk(seen == 0, "R3 short WE pulse ignored", seen, 0);
  endtask

  task automatic t_oe_glitch();
    seen = 0; bus_addr = 20'h00044; bus_data = 16'h4444; idle(2);
    ce_n = 1'b0; idle(2); we_n = 1'b0; idle(8);
    oe_n = 1'b0; idle(2); oe_n = 1'b1; idle(8);
    we_n = 1'b1; idle(3); ce_n = 1'b1; idle(10);
    chk(seen == 1, "R3 short OE pulse ignored", seen, 1);
    chk(last_data == 16'h4444, "R3 data kept", last_data, 16'h4444);
  endtask

  task automatic t_lockout();
    seen = 0; supply_low = 1'b1; idle(5);
    chk(read_mode_req == 1'b1, "R4 read mode while low", read_mode_req, 1);
    full_write(20'h00055, 16'h5555, 10);
    chk(seen == 0, "R4 write ignored while low", seen, 0);
    supply_low = 1'b0; idle(5);
    chk(read_mode_req == 1'b0, "R5 read mode cleared", read_mode_req, 0);
    full_write(20'h00066, 16'h6666, 10);
    chk(seen == 1, "R5 write resumes", seen, 1);
    chk(last_addr == 20'h00066, "R5 address", last_addr, 20'h00066);
  endtask

  task automatic t_lock_midcycle();
    seen = 0; bus_addr = 20'h00077; ce_n = 1'b0; we_n = 1'b0; idle(10);
    supply_low = 1'b1; idle(10); supply_low = 1'b0; idle(10);
    we_n = 1'b1; idle(3); ce_n = 1'b1; idle(10);
    chk(seen == 0, "R5 overlapped cycle rejected", seen, 0);
  endtask

  task automatic t_powerup();
    rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; idle(3);
    rst_n = 1'b1; idle(30); seen = 0;
    we_n = 1'b1; idle(3); ce_n = 1'b1; idle(10);
    chk(seen == 0, "R7 power-up cycle rejected", seen, 0);
    full_write(20'h00088, 16'h8888, 10);
    chk(seen == 1, "R7 later write accepted", seen, 1);
  endtask

  task automatic t_ce_first();
    seen = 0; bus_addr = 20'h00099; ce_n = 1'b0; idle(2); we_n = 1'b0; idle(10);
    ce_n = 1'b1; idle(10); we_n = 1'b1; idle(10);
    chk(seen == 0, "R8 CE-ended cycle ignored", seen, 0);
  endtask

  task automatic t_back_to_back();
    int p1;
    seen = 0; full_write(20'h0ABCD, 16'h0123, 6);
    p1 = seen;
    chk(last_data == 16'h0123, "R1 first of pair", last_data, 16'h0123);
    full_write(20'h0DCBA, 16'h4567, 6);
    chk(p1 == 1 && seen == 2, "R6 one strobe per cycle", seen, 2);
    chk(last_addr == 20'h0DCBA, "R1 second address", last_addr, 20'h0DCBA);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    t_reset();
    t_basic();
    t_oe_low();
    t_ce_high();
    t_we_glitch();
    t_oe_glitch();
    t_lockout();
    t_lock_midcycle();
    t_ce_first();
    t_back_to_back();
    t_powerup();
    do_reset();
    t_basic();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule